// File: doc/BRIEF.md
# Compare-Exchange and Exchange-Add Unit

This block executes two read-modify-write operations on a destination that sits behind a simple request/acknowledge memory port. Compare-exchange tests the accumulator against the destination. On a match it stores the source operand. On a mismatch it returns the destination in the accumulator. Exchange-add stores the sum of the destination and the source, and returns the old destination in the source register. For both operations the unit reports six arithmetic flags.

An operation starts with one `start_i` cycle. That cycle carries the opcode, the operand size (byte, 16-bit or 32-bit), the destination address, the accumulator and source values, and a lock flag. While the lock flag is set, the unit holds a bus-lock output from before the read until after the write, so nothing else can reach the location in between. A one-cycle `done_o` pulse marks the point where the results are valid. The results stay valid until the next operation produces new ones.

Top module: `rmw_xchg_unit`

## Requirements
- R1: Compare-exchange with the low operand-size bits of the accumulator equal to those of the destination sets flag ZF to 1. It writes the source, zero-extended from the operand size, to the destination. `acc_o` equals `acc_i`.
- R2: Compare-exchange with unequal operands sets ZF to 0. `acc_o` takes the destination in its low operand-size bits and keeps the upper bits of `acc_i`. When unlocked, no write is issued. When locked, the destination value read is written back, zero-extended. The write is always issued before done.
- R3: Compare-exchange flags equal those of subtracting the destination from the accumulator at the operand size. `flags_o` bit 0 is carry (borrow), bit 1 is parity (1 when the low result byte has an even number of ones), bit 2 is the carry out of bit 3, bit 3 is zero, bit 4 is sign and bit 5 is signed overflow. `src_o` equals `src_i`.
- R4: Exchange-add writes (destination + source) modulo 2^width to the destination, zero-extended. `src_o` takes the old destination in its low operand-size bits and keeps the upper bits of `src_i`. `acc_o` equals `acc_i`.
- R5: Exchange-add flags follow the addition at the operand size, using the same bit positions as R3. Carry is the carry out of the top bit. Overflow is signed overflow of the sum.
- R6: `size_i` selects the width: 0 means 8 bits, 1 means 16 bits, 2 or 3 means 32 bits. Bits of the read data above the operand size have no effect on any result. `op_i` 0 selects compare-exchange and 1 selects exchange-add.
- R7: For a locked operation, `lock_o` rises at least one cycle before the read request. It stays high through the write acknowledge and is low in the cycle that follows. For an unlocked operation, `lock_o` stays low.
- R8: `done_o` is high for exactly one cycle per operation. When a write occurs, that cycle directly follows the write acknowledge.
- R9: `start_i` has no effect while `busy_o` is high. The running operation completes with the values captured at its own start.
- R10: A memory request, together with its write flag, address and write data, holds steady until `mem_ack_i`.
- R11: After reset, `busy_o`, `done_o`, `mem_req_o` and `lock_o` are low, and `acc_o`, `src_o` and `flags_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| op_i | input | 1 | 0 compare-exchange, 1 exchange-add |
| size_i | input | 2 | Operand width: 0 byte, 1 16-bit, 2/3 32-bit |
| lock_i | input | 1 | Request an atomic operation |
| addr_i | input | ADDR_W | Destination address |
| acc_i | input | DATA_W | Accumulator value |
| src_i | input | DATA_W | Source register value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| acc_o | output | DATA_W | Resulting accumulator |
| src_o | output | DATA_W | Resulting source register |
| flags_o | output | 6 | {OF, SF, ZF, AF, PF, CF} |
| lock_o | output | 1 | Bus lock held across read and write |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
The hardest case to reach is a locked compare-exchange whose comparison fails. It must still perform a write, carrying the unchanged value, while the lock stays held. The unlocked twin of that case must issue no write at all. The stimulus produces both cases by sweeping every pair from a table of edge-value bytes, run with and without lock, at every width. The destination word always carries non-zero bits above the operand size. This shows that those bits neither leak into results nor survive a write. During each operation the stimulus also pulses a conflicting start, which must be dropped.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  localparam int XW = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCK,
    ST_READ,
    ST_EVAL,
    ST_WRITE,
    ST_FIN
  } rmw_state_e;

  // packed so that bit 0 is carry and bit 5 is overflow
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;

  function automatic logic [XW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return XW'(32'h0000_00FF);
      2'd1:    return XW'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic int unsigned top_bit(input logic [1:0] sz);
    case (sz)
      2'd0:    return 7;
      2'd1:    return 15;
      default: return XW - 1;
    endcase
  endfunction

  // keep the bits of old above the operand size, take the low part from fresh
  function automatic logic [XW-1:0] merge_low(input logic [XW-1:0] old,
                                              input logic [XW-1:0] fresh,
                                              input logic [1:0] sz);
    return (old & ~size_mask(sz)) | (fresh & size_mask(sz));
  endfunction

  function automatic flags_t arith_flags(input logic [XW-1:0] lhs,
                                         input logic [XW-1:0] rhs,
                                         input logic [XW-1:0] res,
                                         input logic carry,
                                         input logic is_sub,
                                         input logic [1:0] sz);
    flags_t f;
    int unsigned t;
    logic ls, rs, os;
    t  = top_bit(sz);
    ls = lhs[t];
    rs = rhs[t];
    os = res[t];
    f.cf = carry;
    f.pf = ~^res[7:0];
    f.af = lhs[4] ^ rhs[4] ^ res[4];
    f.zf = ((res & size_mask(sz)) == '0);
    f.sf = os;
    f.of = is_sub ? ((ls ^ rs) & (ls ^ os)) : (~(ls ^ rs) & (ls ^ os));
    return f;
  endfunction

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int DATA_W = XW
) (
  input  logic              op_add,
  input  logic [1:0]        sz,
  input  logic              locked,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dest,
  output logic              need_write,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] acc_res,
  output logic [DATA_W-1:0] src_res,
  output flags_t            flags
);

  logic [DATA_W-1:0] msk, am, dm, sm, diff;
  logic [DATA_W:0]   sum_x;
  logic              borrow, carry, match;

  always_comb begin
    msk    = size_mask(sz);
    am     = acc & msk;
    dm     = dest & msk;
    sm     = src & msk;
    diff   = (am - dm) & msk;
    borrow = (am < dm);
    sum_x  = {1'b0, dm} + {1'b0, sm};
    carry  = sum_x[top_bit(sz) + 1];
    match  = (am == dm);
  end

  always_comb begin
    if (op_add) begin
      flags      = arith_flags(dm, sm, sum_x[DATA_W-1:0] & msk, carry, 1'b0, sz);
      need_write = 1'b1;
      wdata      = sum_x[DATA_W-1:0] & msk;
      acc_res    = acc;
      src_res    = merge_low(src, dest, sz);
    end else begin
      flags      = arith_flags(am, dm, diff, borrow, 1'b1, sz);
      need_write = match | locked;
      wdata      = match ? sm : dm;
      acc_res    = match ? acc : merge_low(acc, dest, sz);
      src_res    = src;
    end
  end

endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lock_req,
  input  logic mem_ack,
  input  logic need_write,
  output logic busy,
  output logic accept,
  output logic rd_hs,
  output logic eval,
  output logic wr_hs,
  output logic done,
  output logic mem_req,
  output logic mem_we,
  output logic lock_out,
  output logic op_locked
);

  rmw_state_e st, st_nx;
  logic       lk_q;

  assign accept    = (st == ST_IDLE) && start;
  assign rd_hs     = (st == ST_READ) && mem_ack;
  assign wr_hs     = (st == ST_WRITE) && mem_ack;
  assign eval      = (st == ST_EVAL);
  assign done      = (st == ST_FIN);
  assign busy      = (st != ST_IDLE);
  assign mem_req   = (st == ST_READ) || (st == ST_WRITE);
  assign mem_we    = (st == ST_WRITE);
  assign op_locked = lk_q;
  assign lock_out  = lk_q && ((st == ST_LOCK) || (st == ST_READ) ||
                              (st == ST_EVAL) || (st == ST_WRITE));

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (start) st_nx = lock_req ? ST_LOCK : ST_READ;
      ST_LOCK:  st_nx = ST_READ;
      ST_READ:  if (mem_ack) st_nx = ST_EVAL;
      ST_EVAL:  st_nx = need_write ? ST_WRITE : ST_FIN;
      ST_WRITE: if (mem_ack) st_nx = ST_FIN;
      ST_FIN:   st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      lk_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (accept) lk_q <= lock_req;
    end
  end

endmodule

// File: rtl/rmw_xchg_unit.sv
module rmw_xchg_unit
  import rmw_pkg::*;
#(
  parameter int DATA_W = XW,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [1:0]        size_i,
  input  logic              lock_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] src_o,
  output logic [5:0]        flags_o,
  output logic              lock_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  // events brought out for the bound checker
  logic accept, rd_hs, eval, wr_hs, op_locked, need_write;

  logic              op_q;
  logic [1:0]        sz_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] acc_q, src_q, dest_q, wdata_q;
  logic [DATA_W-1:0] alu_wdata, alu_acc, alu_src;
  flags_t            alu_flags, flags_q;

  rmw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .lock_req   (lock_i),
    .mem_ack    (mem_ack_i),
    .need_write (need_write),
    .busy       (busy_o),
    .accept     (accept),
    .rd_hs      (rd_hs),
    .eval       (eval),
    .wr_hs      (wr_hs),
    .done       (done_o),
    .mem_req    (mem_req_o),
    .mem_we     (mem_we_o),
    .lock_out   (lock_o),
    .op_locked  (op_locked)
  );

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op_add     (op_q),
    .sz         (sz_q),
    .locked     (op_locked),
    .acc        (acc_q),
    .src        (src_q),
    .dest       (dest_q),
    .need_write (need_write),
    .wdata      (alu_wdata),
    .acc_res    (alu_acc),
    .src_res    (alu_src),
    .flags      (alu_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= 1'b0;
      sz_q    <= 2'd0;
      addr_q  <= '0;
      acc_q   <= '0;
      src_q   <= '0;
      dest_q  <= '0;
      wdata_q <= '0;
      acc_o   <= '0;
      src_o   <= '0;
      flags_q <= '0;
    end else begin
      if (accept) begin
        op_q   <= op_i;
        sz_q   <= size_i;
        addr_q <= addr_i;
        acc_q  <= acc_i;
        src_q  <= src_i;
      end
      if (rd_hs) dest_q <= mem_rdata_i;
      if (eval) begin
        wdata_q <= alu_wdata;
        acc_o   <= alu_acc;
        src_o   <= alu_src;
        flags_q <= alu_flags;
      end
    end
  end

  assign flags_o     = flags_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

endmodule

// File: rtl/rmw_chk.sv
module rmw_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              lock_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic              wr_hs,
  input logic              op_locked
);

  AST_LOCK_LEADS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> !mem_req_o); // R7

  AST_LOCK_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && op_locked) |-> lock_o); // R7

  AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && mem_req_o && mem_we_o && mem_ack_i) |=> !lock_o); // R7

  AST_NO_LOCK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !op_locked) |-> !lock_o); // R7

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hs |=> done_o); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_LOCKED_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_locked) |-> $past(wr_hs)); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) &&
                                   $stable(mem_addr_o) && $stable(mem_wdata_o))); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !done_o) |=> busy_o); // R9

endmodule

bind rmw_xchg_unit rmw_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .lock_o      (lock_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .wr_hs       (wr_hs),
  .op_locked   (op_locked)
);

// File: tb/sim_rmw_xchg_unit.sv
`timescale 1ns/1ps
module sim_rmw_xchg_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic        lock_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] acc_i = '0;
  logic [31:0] src_i = '0;
  logic        busy_o, done_o, lock_o, mem_req_o, mem_we_o;
  logic [31:0] acc_o, src_o, mem_addr_o, mem_wdata_o;
  logic [5:0]  flags_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_word = '0;
  logic [31:0] mem_rdata_i;

  int total = 0;
  int bad = 0;
  int writes = 0;
  int lock_err = 0;
  logic cur_lock = 1'b0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign mem_rdata_i = mem_word;

  rmw_xchg_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .size_i(size_i),
    .lock_i(lock_i), .addr_i(addr_i), .acc_i(acc_i), .src_i(src_i),
    .busy_o(busy_o), .done_o(done_o), .acc_o(acc_o), .src_o(src_o),
    .flags_o(flags_o), .lock_o(lock_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  // memory responder: acknowledges one cycle after a request appears
  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n) mem_ack_i <= 1'b0;
      else if (mem_req_o && !mem_ack_i) begin
        mem_ack_i <= 1'b1;
        if (mem_we_o) begin
          mem_word <= mem_wdata_o;
          writes   <= writes + 1;
        end
      end else mem_ack_i <= 1'b0;
    end
  end

  // lock monitor (R7)
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && busy_o) begin
        if (mem_req_o && cur_lock && !lock_o) lock_err = lock_err + 1;
        if (!cur_lock && lock_o) lock_err = lock_err + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
  endfunction

  function automatic longint sval(input longint v, input int w);
    return (v >= (longint'(1) << (w - 1))) ? v - (longint'(1) << w) : v;
  endfunction

  function automatic bit even_ones(input longint v);
    int n = 0;
    for (int k = 0; k < 8; k++) n += int'((v >> k) & 1);
    return (n % 2) == 0;
  endfunction

  // flag word {OF,SF,ZF,AF,PF,CF}
  function automatic logic [5:0] exp_flags(input longint a, input longint b,
                                           input bit is_sub, input int w);
    longint m = (longint'(1) << w) - 1;
    longint full, r, sr;
    bit cf, of;
    if (is_sub) begin
      full = a - b;
      cf   = (a < b);
      sr   = sval(a, w) - sval(b, w);
    end else begin
      full = a + b;
      cf   = (full > m);
      sr   = sval(a, w) + sval(b, w);
    end
    r  = full & m;
    of = (sr > ((longint'(1) << (w - 1)) - 1)) || (sr < -(longint'(1) << (w - 1)));
    return {of, bit'((r >> (w - 1)) & 1), (r == 0),
            bit'(((a & 15) + (is_sub ? -(b & 15) : (b & 15))) >> 4 != 0),
            even_ones(r), cf};
  endfunction

  function automatic logic [31:0] widen(input logic [7:0] p, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'h0, p};
      2'd1:    return {16'h0, p, p ^ 8'h3C};
      default: return {p, ~p, p ^ 8'h66, p};
    endcase
  endfunction

  task automatic run_op(input bit op, input logic [1:0] sz, input bit lk,
                        input logic [31:0] a, input logic [31:0] s, input logic [31:0] d);
    int w = width_of(sz);
    longint m = (longint'(1) << w) - 1;
    logic [31:0] msk = 32'(m);
    logic [31:0] a_full = (32'h6B2D_9F41 & ~msk) | (a & msk);
    logic [31:0] s_full = (32'h1357_9BDF & ~msk) | (s & msk);
    logic [31:0] d_full = (32'hA5C3_1E77 & ~msk) | (d & msk);
    logic [31:0] e_acc, e_src, e_mem;
    logic [5:0]  e_fl;
    int e_wr, w0, l0, guard;
    longint la = longint'(a & msk), ls = longint'(s & msk), ld = longint'(d & msk);
    string tg;

    if (op == 1'b0) begin
      e_fl  = exp_flags(la, ld, 1'b1, w);
      e_src = s_full;
      if (la == ld) begin
        e_acc = a_full; e_mem = s & msk; e_wr = 1; tg = "R1";
      end else begin
        e_acc = (a_full & ~msk) | (d & msk);
        e_mem = lk ? (d & msk) : d_full;
        e_wr  = lk ? 1 : 0;
        tg    = "R2";
      end
    end else begin
      e_fl  = exp_flags(ld, ls, 1'b0, w);
      e_acc = a_full;
      e_src = (s_full & ~msk) | (d & msk);
      e_mem = 32'((ld + ls) & m);
      e_wr  = 1;
      tg    = "R4";
    end

    @(negedge clk);
    mem_word = d_full;
    w0 = writes; l0 = lock_err;
    cur_lock = lk;
    op_i = op; size_i = sz; lock_i = lk; acc_i = a_full; src_i = s_full;
    addr_i = {a[15:0], d[15:0]};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    // conflicting start while busy (R9)
    start_i = 1'b1; op_i = ~op; acc_i = ~a_full; src_i = ~s_full; lock_i = ~lk;
    @(negedge clk);
    start_i = 1'b0;
    guard = 0;
    while (!done_o && guard < 60) begin
      @(negedge clk);
      guard++;
    end
    if (!done_o) begin
      total++; bad++;
      $display("FAIL R8: actual=no done expected=done within 60 cycles");
      return;
    end
    check($sformatf("%s/R9 acc_o", tg), acc_o, e_acc);
    check(op ? "R4 src_o" : "R3 src_o", src_o, e_src);
    check(op ? "R5 flags" : "R3 flags", {26'h0, flags_o}, {26'h0, e_fl});
    check($sformatf("%s/R6 mem", tg), mem_word, e_mem);
    check($sformatf("%s write count", tg), 32'(writes - w0), 32'(e_wr));
    check("R7 lock", 32'(lock_err - l0), 32'd0);
    check("R1 zf", {31'h0, flags_o[3]}, {31'h0, (op == 1'b0) ? (la == ld) : e_fl[3]});
    @(negedge clk);
    check("R8 done pulse", {31'h0, done_o}, 32'h0);
  endtask

  // global watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [7:0] pats [16];

  initial begin
    pats = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h0F, 8'h10, 8'h55,
             8'hAA, 8'hFE, 8'h81, 8'h3C, 8'hC3, 8'h08, 8'hF0, 8'h7E};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 busy", {31'h0, busy_o}, 32'h0);
    check("R11 done", {31'h0, done_o}, 32'h0);
    check("R11 req", {31'h0, mem_req_o}, 32'h0);
    check("R11 lock", {31'h0, lock_o}, 32'h0);
    check("R11 acc", acc_o, 32'h0);
    check("R11 src", src_o, 32'h0);
    check("R11 flags", {26'h0, flags_o}, 32'h0);

    for (int sz = 0; sz < 4; sz++)
      for (int op = 0; op < 2; op++)
        for (int lk = 0; lk < 2; lk++)
          for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
              run_op(op[0], sz[1:0], lk[0],
                     widen(pats[i], sz[1:0]),
                     widen(pats[(i + j + 5) % 16] ^ 8'h21, sz[1:0]),
                     widen(pats[j], sz[1:0]));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule